// File: doc/BRIEF.md
# Configurable Bidirectional I/O Cell

This cell sits on the edge of a programmable logic fabric. It connects one fabric signal pair to a general-purpose pin of the surrounding system. A single configuration flip-flop chooses the direction of the cell. That flip-flop is one stage of a serial configuration chain: it captures the chain input on each rising edge of the configuration clock and passes its content to the next cell through the chain output.

A global active-low isolation input puts every cell into input mode, whatever its stored bit holds. This keeps a fabric whose configuration has not yet been loaded from driving the pin. The override is purely combinational.

In either mode the data path that is not in use is forced to logic 0. Random fabric activity therefore never reaches the pin, and pin activity never reaches the fabric. The direction indication toward the pin is active-low: 0 enables the output driver.

Top module: `io_cell_bidir`

## Requirements
- R1: While the configuration reset is low, the stored direction bit is 1. The chain output reads 1, and the cell is in input mode (`pin_oe_n` = 1).
- R2: On each rising configuration clock edge outside reset, the stored bit takes the value of `cfg_sin`. From that edge until the next one, `cfg_sout` presents the stored bit.
- R3: With isolation released (`isol_n` = 1) and a stored bit of 1, the cell is in input mode and `pin_oe_n` reads 1.
- R4: With isolation released and a stored bit of 0, the cell is in output mode and `pin_oe_n` reads 0.
- R5: While `isol_n` is 0, `pin_oe_n` reads 1 for either stored bit. The change takes effect without any configuration clock edge.
- R6: In input mode, `pin_out` is held at 0 and does not follow `fab_to_pin`.
- R7: In output mode, `fab_from_pin` is held at 0 and does not follow `pin_in`.
- R8: In input mode, `fab_from_pin` equals `pin_in`.
- R9: In output mode, `pin_out` equals `fab_to_pin`.
- R10: Isolation leaves the stored bit unchanged. `cfg_sout` keeps its value while isolated. When isolation is released, the stored mode returns at once, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration chain clock, rising edge |
| cfg_rst_n | input | 1 | Asynchronous active-low configuration reset, loads input mode |
| cfg_sin | input | 1 | Serial configuration data from the previous cell |
| cfg_sout | output | 1 | Stored direction bit, serial data to the next cell |
| isol_n | input | 1 | Active-low isolation, forces input mode |
| fab_to_pin | input | DATA_W | Data from the fabric toward the pin |
| fab_from_pin | output | DATA_W | Data from the pin into the fabric, 0 in output mode |
| pin_in | input | DATA_W | Data arriving from the system pin |
| pin_out | output | DATA_W | Data toward the system pin, 0 in input mode |
| pin_oe_n | output | 1 | Active-low output enable toward the pin |

## Verification
The assertions watch four properties at every configuration clock edge: isolation always yields input mode, the enable tracks the stored bit, the unused path is always 0, and the active path always passes data through. They also check that the chain output always shows the bit captured at the previous edge. The bench scenarios cover what the assertions cannot see: the value during reset, and the isolation override and its release between clock edges with no edge occurring. They also confirm that the stored bit survives a period of isolation.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } io_dir_e;

  // Output drive is allowed only when not isolated and the stored bit selects output
  function automatic logic drive_allowed(input logic isol_n, input logic dir_bit);
    return isol_n & (io_dir_e'(dir_bit) == DIR_OUT);
  endfunction

  // Pass data when enabled, otherwise present the idle level
  function automatic logic gate_bit(input logic en, input logic data, input logic idle);
    return en ? data : idle;
  endfunction

endpackage

// File: rtl/io_dir_cfg.sv
module io_dir_cfg #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic cfg_clk,
  input  logic cfg_rst_n,
  input  logic cfg_sin,
  output logic dir_q
);

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) dir_q <= RST_VAL;
    else            dir_q <= cfg_sin;
  end

endmodule

// File: rtl/io_dir_decode.sv
module io_dir_decode
  import io_cell_pkg::*;
(
  input  logic isol_n,
  input  logic dir_q,
  output logic drive_en,
  output logic oe_n
);

  assign drive_en = drive_allowed(isol_n, dir_q);
  assign oe_n     = ~drive_en;

endmodule

// File: rtl/io_data_gate.sv
module io_data_gate
  import io_cell_pkg::*;
#(
  parameter int DATA_W   = 1,
  parameter bit IDLE_LVL = 1'b0
) (
  input  logic              drive_en,
  input  logic [DATA_W-1:0] fab_to_pin,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] fab_from_pin
);

  logic recv_en;
  assign recv_en = ~drive_en;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign pin_out[i]      = gate_bit(drive_en, fab_to_pin[i], IDLE_LVL);
    assign fab_from_pin[i] = gate_bit(recv_en,  pin_in[i],     IDLE_LVL);
  end

endmodule

// File: rtl/io_cell_bidir.sv
module io_cell_bidir #(
  parameter int DATA_W      = 1,
  parameter bit CFG_RST_VAL = 1'b1,
  parameter bit IDLE_LVL    = 1'b0
) (
  input  logic              cfg_clk,
  input  logic              cfg_rst_n,
  input  logic              cfg_sin,
  output logic              cfg_sout,
  input  logic              isol_n,
  input  logic [DATA_W-1:0] fab_to_pin,
  output logic [DATA_W-1:0] fab_from_pin,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe_n
);

  logic dir_q;
  logic drive_en;

  io_dir_cfg #(.RST_VAL(CFG_RST_VAL)) u_cfg (
    .cfg_clk  (cfg_clk),
    .cfg_rst_n(cfg_rst_n),
    .cfg_sin  (cfg_sin),
    .dir_q    (dir_q)
  );

  io_dir_decode u_dec (
    .isol_n  (isol_n),
    .dir_q   (dir_q),
    .drive_en(drive_en),
    .oe_n    (pin_oe_n)
  );

  io_data_gate #(.DATA_W(DATA_W), .IDLE_LVL(IDLE_LVL)) u_gate (
    .drive_en    (drive_en),
    .fab_to_pin  (fab_to_pin),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .fab_from_pin(fab_from_pin)
  );

  assign cfg_sout = dir_q;

endmodule

// File: rtl/io_cell_bidir_chk.sv
module io_cell_bidir_chk #(
  parameter int DATA_W = 1
) (
  input logic              cfg_clk,
  input logic              cfg_rst_n,
  input logic              cfg_sin,
  input logic              cfg_sout,
  input logic              isol_n,
  input logic [DATA_W-1:0] fab_to_pin,
  input logic [DATA_W-1:0] fab_from_pin,
  input logic [DATA_W-1:0] pin_in,
  input logic [DATA_W-1:0] pin_out,
  input logic              pin_oe_n
);

  logic past_ok;
  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) past_ok <= 1'b0;
    else            past_ok <= 1'b1;
  end

  AST_CHAIN_CAPTURE: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    past_ok |-> (cfg_sout == $past(cfg_sin)));                      // R2

  AST_MODE_FOLLOWS_BIT: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    isol_n |-> (pin_oe_n == cfg_sout));                             // R3

  AST_ISOL_FORCES_INPUT: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !isol_n |-> pin_oe_n);                                          // R5

  AST_INPUT_PIN_QUIET: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    pin_oe_n |-> (pin_out == '0));                                  // R6

  AST_OUTPUT_FABRIC_QUIET: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !pin_oe_n |-> (fab_from_pin == '0));                            // R7

  AST_INPUT_PASS: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    pin_oe_n |-> (fab_from_pin == pin_in));                         // R8

  AST_OUTPUT_PASS: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !pin_oe_n |-> (pin_out == fab_to_pin));                         // R9

endmodule

bind io_cell_bidir io_cell_bidir_chk #(.DATA_W(DATA_W)) u_chk (
  .cfg_clk     (cfg_clk),
  .cfg_rst_n   (cfg_rst_n),
  .cfg_sin     (cfg_sin),
  .cfg_sout    (cfg_sout),
  .isol_n      (isol_n),
  .fab_to_pin  (fab_to_pin),
  .fab_from_pin(fab_from_pin),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe_n    (pin_oe_n)
);

// File: tb/io_cell_bidir_test.sv
`timescale 1ns/100ps
module io_cell_bidir_test;

  localparam int DATA_W = 1;

  logic              cfg_clk = 1'b0;
  logic              cfg_rst_n = 1'b0;
  logic              cfg_sin = 1'b1;
  logic              cfg_sout;
  logic              isol_n = 1'b1;
  logic [DATA_W-1:0] fab_to_pin = '0;
  logic [DATA_W-1:0] fab_from_pin;
  logic [DATA_W-1:0] pin_in = '0;
  logic [DATA_W-1:0] pin_out;
  logic              pin_oe_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 cfg_clk = ~cfg_clk;

  io_cell_bidir #(.DATA_W(DATA_W)) uut (
    .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .cfg_sin(cfg_sin), .cfg_sout(cfg_sout),
    .isol_n(isol_n), .fab_to_pin(fab_to_pin), .fab_from_pin(fab_from_pin),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // load the stored bit: drive at negedge, captured at next posedge, settle at following negedge
  task automatic load_bit(input logic b);
    @(negedge cfg_clk); cfg_sin = b;
    @(negedge cfg_clk); #0.5;
  endtask

  task automatic t_reset;
    cfg_rst_n = 1'b0; cfg_sin = 1'b0; isol_n = 1'b1;
    fab_to_pin = 1'b1; pin_in = 1'b1;
    repeat (3) @(negedge cfg_clk);
    #0.5;
    check("R1", "cfg_sout in reset", cfg_sout, 1);
    check("R1", "pin_oe_n in reset", pin_oe_n, 1);
    check("R1", "pin_out in reset", pin_out, 0);
    cfg_sin = 1'b1;
    @(negedge cfg_clk); cfg_rst_n = 1'b1;
  endtask

  task automatic t_shift;
    load_bit(1'b0);
    check("R2", "cfg_sout after shift 0", cfg_sout, 0);
    load_bit(1'b1);
    check("R2", "cfg_sout after shift 1", cfg_sout, 1);
    @(negedge cfg_clk); cfg_sin = 1'b0; #0.5;
    check("R2", "cfg_sout before edge", cfg_sout, 1);
    @(negedge cfg_clk); #0.5;
    check("R2", "cfg_sout after edge", cfg_sout, 0);
  endtask

  task automatic t_input_mode;
    isol_n = 1'b1;
    load_bit(1'b1);
    check("R3", "pin_oe_n input mode", pin_oe_n, 1);
    for (int v = 0; v < 4; v++) begin
      fab_to_pin = v[0]; pin_in = v[1]; #0.5;
      check("R6", "pin_out quiet", pin_out, 0);
      check("R8", "fab_from_pin pass", fab_from_pin, {31'd0, v[1]});
    end
  endtask

  task automatic t_output_mode;
    isol_n = 1'b1;
    load_bit(1'b0);
    check("R4", "pin_oe_n output mode", pin_oe_n, 0);
    for (int v = 0; v < 4; v++) begin
      fab_to_pin = v[0]; pin_in = v[1]; #0.5;
      check("R7", "fab_from_pin quiet", fab_from_pin, 0);
      check("R9", "pin_out pass", pin_out, {31'd0, v[0]});
    end
  endtask

  task automatic t_isolation;
    load_bit(1'b0);
    fab_to_pin = 1'b1; pin_in = 1'b1;
    @(negedge cfg_clk); #0.3;
    isol_n = 1'b0; #0.3;
    check("R5", "pin_oe_n isolated, bit 0, no edge", pin_oe_n, 1);
    check("R5", "pin_out isolated", pin_out, 0);
    check("R5", "fab_from_pin isolated", fab_from_pin, 1);
    repeat (3) @(negedge cfg_clk);
    #0.5;
    check("R10", "cfg_sout kept while isolated", cfg_sout, 0);
    check("R5", "pin_oe_n still isolated", pin_oe_n, 1);
    isol_n = 1'b1; #0.3;
    check("R10", "output mode back on release", pin_oe_n, 0);
    check("R10", "pin_out back on release", pin_out, 1);
    load_bit(1'b1);
    isol_n = 1'b0; #0.3;
    check("R5", "pin_oe_n isolated, bit 1", pin_oe_n, 1);
    isol_n = 1'b1; #0.3;
    check("R10", "input mode kept on release", pin_oe_n, 1);
  endtask

  initial begin
    t_reset();
    t_shift();
    t_input_mode();
    t_output_mode();
    t_isolation();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge cfg_clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule